// File: doc/BRIEF.md
# ADC Conversion Sequencer with Accumulation

This block sits between an 8-bit configuration register that software can write and a successive-approximation converter core. It divides the functional clock by a programmable amount to make the converter clock enable. It hands conversion requests to the core over a request/done/data handshake and sums one, four, eight or sixteen 10-bit results into a 16-bit result register. When the whole programmed series has been summed, it raises an end-of-conversion strobe and a window-compare evaluation strobe. Each strobe lasts one functional-clock cycle.

With burst mode off, every conversion in a series waits for its own convert-start pulse. With burst mode on, one convert-start runs the whole series, and each conversion is requested on the next converter clock enable. A convert-start that arrives while a conversion is pending or in progress is dropped. The repeat count and the justification choice are captured when a series begins.

Top module: `adc_seq_accum`

## Requirements
- R1: After reset, `cfg_q` reads 0xF8. A cycle with `cfg_we` high loads `cfg_wdata` into `cfg_q` at the next edge. Bits 7..3 form the divider field, bits 2..1 form the repeat code and bit 0 is a stored attenuation flag.
- R2: `sar_clk_en` is high for one cycle in every (divider field + 1) cycles. A field of 0 keeps it high on every cycle.
- R3: Repeat code 00 sums 1 conversion, 01 sums 4, 10 sums 8 and 11 sums 16. `result` holds the right-justified sum of the series, and the sum never overflows.
- R4: `eoc_irq` and `win_irq` pulse high together for exactly one cycle. The pulse comes in the cycle after the `sar_done` of the last conversion of a series, and never earlier in the series.
- R5: With `burst_en` low, once a conversion of an unfinished series completes, no further `sar_req` is issued until another `conv_start` arrives.
- R6: With `burst_en` high, a single `conv_start` produces every conversion of the series. Each `sar_req` is a one-cycle pulse that coincides with `sar_clk_en`.
- R7: A `conv_start` that arrives while a request is pending or a conversion is in progress is ignored. It adds no conversions and no strobes.
- R8: With repeat code 00 and `left_just` high at the start, `result` is the sample shifted left by 6. With any other repeat code, `left_just` is ignored and the result stays right-justified.
- R9: The sum restarts from zero at the first conversion of each new series. An earlier series does not contribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_q | output | 8 | Current configuration value |
| burst_en | input | 1 | Self-timed series when high |
| left_just | input | 1 | Left-justify request for single conversions |
| conv_start | input | 1 | Convert-start pulse |
| sar_clk_en | output | 1 | Converter clock enable from the divider |
| sar_req | output | 1 | Conversion request pulse to the core |
| sar_done | input | 1 | Conversion complete from the core |
| sar_data | input | 10 | Sample from the core, valid with sar_done |
| result | output | 16 | Accumulated result register |
| eoc_irq | output | 1 | End-of-series strobe |
| win_irq | output | 1 | Window-compare evaluation strobe |

## Verification
The bench runs series in non-burst mode and checks that a design which kept requesting on its own would show extra requests while no start is given. It fires starts into the middle of a sixteen-sample burst: a design that honoured them would issue more than sixteen requests or a second strobe. It runs two series back to back, so a sum that is not cleared shows up as too large a result. It sets left-justify with both repeat codes 00 and 01: a design that shifted an accumulated sum, or ignored the shift for a single sample, would show the wrong value. Divider fields of 0 and 5 catch an off-by-one period.

// File: rtl/adc_seq_accum.sv
module adc_seq_accum #(
  parameter int DATA_W = 10,
  parameter int ACC_W = 16,
  parameter logic [7:0] CFG_RST = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_q,
  input  logic              burst_en,
  input  logic              left_just,
  input  logic              conv_start,
  output logic              sar_clk_en,
  output logic              sar_req,
  input  logic              sar_done,
  input  logic [DATA_W-1:0] sar_data,
  output logic [ACC_W-1:0]  result,
  output logic              eoc_irq,
  output logic              win_irq
);
  localparam int LJ_SH = ACC_W - DATA_W;
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(16 * ((1 << DATA_W) - 1));

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_BUSY, S_HOLD} state_t;

  state_t           state;
  logic [4:0]       div_cnt;
  logic [4:0]       cnt, tgt, tgt_new;
  logic             first, lj_q;
  logic [ACC_W-1:0] acc, sum_nxt, final_val;
  logic             last;

  always_ff @(posedge clk)
    if (!rst_n) cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wdata;

  assign sar_clk_en = (div_cnt == 5'd0);

  always_ff @(posedge clk)
    if (!rst_n) div_cnt <= '0;
    else if (sar_clk_en) div_cnt <= cfg_q[7:3];
    else div_cnt <= div_cnt - 5'd1;

  always_comb
    case (cfg_q[2:1])
      2'b00:   tgt_new = 5'd1;
      2'b01:   tgt_new = 5'd4;
      2'b10:   tgt_new = 5'd8;
      default: tgt_new = 5'd16;
    endcase

  assign sar_req   = (state == S_ARM) && sar_clk_en;
  assign sum_nxt   = (first ? '0 : acc) + ACC_W'(sar_data);
  assign final_val = lj_q ? {sar_data, {LJ_SH{1'b0}}} : sum_nxt;
  assign last      = (cnt + 5'd1 == tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      tgt     <= 5'd1;
      first   <= 1'b0;
      lj_q    <= 1'b0;
      acc     <= '0;
      result  <= '0;
      eoc_irq <= 1'b0;
      win_irq <= 1'b0;
    end else begin
      eoc_irq <= 1'b0;
      win_irq <= 1'b0;
      case (state)
        S_IDLE:
          if (conv_start) begin
            state <= S_ARM;
            first <= 1'b1;
            cnt   <= '0;
            tgt   <= tgt_new;
            lj_q  <= left_just && (cfg_q[2:1] == 2'b00);
          end
        S_HOLD:
          if (conv_start) state <= S_ARM;
        S_ARM:
          if (sar_clk_en) state <= S_BUSY;
        S_BUSY:
          if (sar_done) begin
            acc   <= sum_nxt;
            first <= 1'b0;
            cnt   <= cnt + 5'd1;
            if (last) begin
              state   <= S_IDLE;
              result  <= final_val;
              eoc_irq <= 1'b1;
              win_irq <= 1'b1;
            end else begin
              state <= burst_en ? S_ARM : S_HOLD;
            end
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  a_r4_eoc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> $past(sar_done));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= ACC_MAX);

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= tgt);
endmodule

// File: tb/tb_adc_seq_accum.sv
module tb_adc_seq_accum;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, burst_en = 0, left_just = 0, conv_start = 0;
  logic [7:0] cfg_wdata = 0, cfg_q;
  logic sar_clk_en, sar_req, sar_done = 0, eoc_irq, win_irq;
  logic [9:0] sar_data = 0;
  logic [15:0] result;

  int checks = 0, errors = 0, cyc = 0;
  int req_cnt = 0, eoc_cnt = 0, stub_sum = 0, last_data = 0, dv = 5;
  int pend = 0, lat = 0, last_tick = 0, gap = 0;
  bit run_chk = 0;

  int m_cfg, m_div, m_st, m_res, m_eoc, m_acc, m_cnt, m_tgt, m_first, m_lj;

  adc_seq_accum dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .burst_en(burst_en), .left_just(left_just), .conv_start(conv_start),
    .sar_clk_en(sar_clk_en), .sar_req(sar_req), .sar_done(sar_done), .sar_data(sar_data),
    .result(result), .eoc_irq(eoc_irq), .win_irq(win_irq));

  always #2 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // converter core stub and event counters
  always @(posedge clk) begin
    cyc++;
    sar_done <= 1'b0;
    if (pend != 0) begin
      if (lat == 0) begin
        dv = (dv * 13 + 7) % 1024;
        sar_done <= 1'b1;
        sar_data <= 10'(dv);
        stub_sum += dv;
        last_data = dv;
        pend = 0;
      end else lat--;
    end
    if (rst_n && sar_req) begin pend = 1; lat = 2; req_cnt++; end
    if (rst_n && eoc_irq) eoc_cnt++;
    if (rst_n && sar_clk_en) begin gap = cyc - last_tick; last_tick = cyc; end
  end

  // behavioural reference model
  always @(posedge clk) begin
    int s, tick;
    if (!rst_n) begin
      m_cfg = 248; m_div = 0; m_st = 0; m_res = 0; m_eoc = 0; m_acc = 0;
      m_cnt = 0; m_tgt = 1; m_first = 0; m_lj = 0;
    end else begin
      tick = (m_div == 0);
      m_eoc = 0;
      case (m_st)
        0: if (conv_start) begin
             m_st = 1; m_first = 1; m_cnt = 0;
             case ((m_cfg >> 1) & 3) 0: m_tgt = 1; 1: m_tgt = 4; 2: m_tgt = 8; default: m_tgt = 16; endcase
             m_lj = (left_just && ((m_cfg >> 1) & 3) == 0);
           end
        3: if (conv_start) m_st = 1;
        1: if (tick) m_st = 2;
        2: if (sar_done) begin
             s = (m_first ? 0 : m_acc) + int'(sar_data);
             m_acc = s; m_first = 0; m_cnt++;
             if (m_cnt == m_tgt) begin
               m_st = 0; m_eoc = 1;
               m_res = m_lj ? int'(sar_data) * 64 : s;
             end else m_st = burst_en ? 1 : 3;
           end
        default: m_st = 0;
      endcase
      m_div = tick ? (m_cfg >> 3) : m_div - 1;
      if (cfg_we) m_cfg = int'(cfg_wdata);
    end
  end

  always @(negedge clk) if (rst_n && run_chk) begin
    check("R1 cfg_q", int'(cfg_q), m_cfg);
    check("R2 sar_clk_en", int'(sar_clk_en), int'(m_div == 0));
    check("R5 sar_req", int'(sar_req), int'(m_st == 1 && m_div == 0));
    check("R4 eoc_irq", int'(eoc_irq), m_eoc);
    check("R4 win_irq", int'(win_irq), m_eoc);
    check("R3 result", int'(result), m_res);
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(int v);
    @(negedge clk); cfg_we = 1; cfg_wdata = 8'(v);
    @(negedge clk); cfg_we = 0;
    cycles(40);
  endtask

  task automatic pulse_start();
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
  endtask

  task automatic wait_eoc(int target);
    for (int i = 0; i < 3000 && eoc_cnt < target; i++) @(negedge clk);
    cycles(2);
  endtask

  task automatic begin_series();
    stub_sum = 0; req_cnt = 0;
  endtask

  initial begin
    int e0;
    cycles(4);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset cfg", int'(cfg_q), 248);
    check("R1 reset result", int'(result), 0);
    check("R4 reset eoc", int'(eoc_irq), 0);
    run_chk = 1;

    // R2 divider field 0
    write_cfg(8'b00000_00_0);
    check("R1 cfg write", int'(cfg_q), 0);
    check("R2 gap field 0", gap, 1);

    // R3 single conversion
    burst_en = 0; left_just = 0;
    begin_series(); e0 = eoc_cnt; pulse_start(); wait_eoc(e0 + 1);
    check("R3 single sum", int'(result), stub_sum);
    check("R4 single strobe count", eoc_cnt - e0, 1);

    // R8 left justify with single conversion
    left_just = 1;
    begin_series(); e0 = eoc_cnt; pulse_start(); wait_eoc(e0 + 1);
    check("R8 left justified", int'(result), last_data * 64);

    // R5 non-burst, repeat 4, left_just ignored (R8)
    write_cfg(8'b00000_01_0);
    begin_series(); e0 = eoc_cnt; pulse_start(); cycles(60);
    check("R5 one req per start", req_cnt, 1);
    check("R4 no early strobe", eoc_cnt - e0, 0);
    for (int k = 0; k < 3; k++) begin pulse_start(); cycles(20); end
    wait_eoc(e0 + 1);
    check("R5 four reqs", req_cnt, 4);
    check("R8 ignored for repeat 4", int'(result), stub_sum);
    left_just = 0;

    // R6 burst, repeat 8, divider 5
    write_cfg(8'b00101_10_0);
    check("R2 gap field 5", gap, 6);
    burst_en = 1;
    begin_series(); e0 = eoc_cnt; pulse_start(); wait_eoc(e0 + 1);
    check("R6 burst reqs", req_cnt, 8);
    check("R3 sum of 8", int'(result), stub_sum);
    check("R4 burst strobe count", eoc_cnt - e0, 1);

    // R7 extra starts during a 16-sample burst; R9 fresh sum
    write_cfg(8'b00011_11_0);
    begin_series(); e0 = eoc_cnt; pulse_start();
    for (int k = 0; k < 4; k++) begin cycles(15); pulse_start(); end
    wait_eoc(e0 + 1);
    cycles(100);
    check("R7 reqs with extra starts", req_cnt, 16);
    check("R7 strobe count", eoc_cnt - e0, 1);
    check("R3 sum of 16", int'(result), stub_sum);

    begin_series(); e0 = eoc_cnt; pulse_start(); wait_eoc(e0 + 1);
    check("R9 second series sum", int'(result), stub_sum);
    cycles(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule